// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Tracker

This block watches the clock-enable line and the registered command pins of a low-power SDRAM from the controller side. It follows the power state the memory should be in: all banks idle, active, clock suspend, power down, self refresh and deep power down. Every rising edge of the clock, it combines the clock-enable level sampled on the previous edge, the level on this edge and the decoded command. From these it works out the next state, and it raises single-cycle flags when a command or a clock-enable pattern breaks the power rules.

Deep power down needs a long quiet window on exit. Only no-operation or deselect may be issued during that window. The window length is the parameter `GUARD_CYCLES`, given in clock cycles. Set it to the number of cycles that covers 100 microseconds at the memory clock used. While the window runs, `guard_busy` is high. A single input, `banks_idle`, comes from the bank logic and reports whether every bank is precharged. The block has no data stream, so every pin is a plain level with no handshake.

Top module: `sdram_cke_tracker`

## Requirements
- R1: After reset, `pwr_state` is 0 (idle), `illegal_cmd`, `invalid_cke` and `guard_busy` are low, and the previously sampled clock enable is taken as high. All outputs are registered: they show the decision made at the most recent rising edge.
- R2: State codes are idle=0, active=1, suspend=2, power down=3, self refresh=4 and deep power down=5. The refresh command is encoded as {cs_n,ras_n,cas_n,we_n}=0001. From idle with `banks_idle` high, clock enable falling (high then low) together with the refresh command moves to self refresh (4). With clock enable staying high, the refresh command leaves the state idle.
- R3: From idle with `banks_idle` high, clock enable falling with the burst-stop encoding 0110 moves to deep power down (5).
- R4: From idle with `banks_idle` high, clock enable falling with any other command moves to power down (3).
- R5: With `banks_idle` low, clock enable falling moves to suspend (2). In suspend, clock enable low holds the state. Clock enable high returns to active (1), or to idle (0) if `banks_idle` is high.
- R6: In power down, self refresh or deep power down, clock enable low on both the previous and the current edge keeps the state.
- R7: In power down or self refresh, the first edge with clock enable high after a low one goes to idle if the command is deselect (cs_n=1) or no-operation (0111). With any other command it pulses `illegal_cmd` and keeps the state.
- R8: In power down, self refresh or deep power down, a previous-edge clock enable of high pulses `invalid_cke` and keeps the state.
- R9: In deep power down, a low-to-high clock enable goes to idle and raises `guard_busy`. `guard_busy` then stays high for exactly `GUARD_CYCLES` further edges that have clock enable high.
- R10: On the deep power down exit edge, and on every edge while `guard_busy` is high, any command other than deselect or no-operation pulses `illegal_cmd`. The state stays idle for the whole window.
- R11: Clock enable low while `guard_busy` is high restarts the full window and does not enter any low-power state.
- R12: In idle or active with `banks_idle` low, the mode-set encoding 0000 pulses `illegal_cmd`. With `banks_idle` high, it raises no flag.
- R13: Each flag is high only in the cycle after an offending edge. A following edge with a legal command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Sampled clock-enable line |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | High when every bank is precharged |
| pwr_state | output | 3 | Tracked power state code (see R2) |
| illegal_cmd | output | 1 | One-cycle pulse: command breaks a power rule |
| invalid_cke | output | 1 | One-cycle pulse: clock enable high before an edge in a low-power state |
| guard_busy | output | 1 | Deep power down exit window running |

## Verification
The deep power down exit edge can carry a forbidden command. That edge starts the quiet window and raises `illegal_cmd` in the same cycle. The bench drives a read on that edge and expects `pwr_state` idle, `guard_busy` high and `illegal_cmd` high together. A second overlap comes from dropping clock enable inside the window while issuing a forbidden command. That single edge must both restart the count and raise the flag, and the bench judges it by checking that the flag is high and that `guard_busy` stays high for a full fresh window. Random runs with weighted commands keep creating these overlaps, and a cycle-accurate model in the bench checks each one.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

  typedef enum logic [2:0] {
    PS_IDLE    = 3'd0,
    PS_ACTIVE  = 3'd1,
    PS_SUSPEND = 3'd2,
    PS_PDOWN   = 3'd3,
    PS_SREF    = 3'd4,
    PS_DPD     = 3'd5
  } pwr_state_t;

  typedef enum logic [2:0] {
    CK_DESEL   = 3'd0,
    CK_NOP     = 3'd1,
    CK_REFRESH = 3'd2,
    CK_BSTOP   = 3'd3,
    CK_MODESET = 3'd4,
    CK_OTHER   = 3'd5
  } cmd_kind_t;

  function automatic logic cmd_is_quiet(cmd_kind_t k);
    return (k == CK_DESEL) || (k == CK_NOP);
  endfunction

  function automatic logic state_is_lowpower(pwr_state_t s);
    return (s == PS_PDOWN) || (s == PS_SREF) || (s == PS_DPD);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_pwr_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_t kind
);

  logic [2:0] strobes;
  assign strobes = {ras_n, cas_n, we_n};

  always_comb begin
    if (cs_n) begin
      kind = CK_DESEL;
    end else begin
      unique case (strobes)
        3'b111:  kind = CK_NOP;
        3'b001:  kind = CK_REFRESH;
        3'b110:  kind = CK_BSTOP;
        3'b000:  kind = CK_MODESET;
        default: kind = CK_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/cke_history.sv
module cke_history #(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic cke_prev
);

  always_ff @(posedge clk) begin
    if (!rst_n) cke_prev <= RESET_LEVEL;
    else        cke_prev <= cke;
  end

endmodule

// File: rtl/exit_guard_timer.sv
module exit_guard_timer #(
  parameter int unsigned GUARD_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cke,
  output logic busy
);

  localparam int unsigned CNT_W = $clog2(GUARD_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GUARD_CYCLES);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= RELOAD;
    end else if (remain != '0) begin
      if (!cke) remain <= RELOAD;
      else      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import sdram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cke_prev,
  input  cmd_kind_t  cmd,
  input  logic       banks_idle,
  input  logic       guard_busy,
  output pwr_state_t state,
  output logic       guard_start,
  output logic       illegal_q,
  output logic       invalid_q
);

  pwr_state_t nxt;
  pwr_state_t base_state;
  logic       quiet;
  logic       ill_d;
  logic       inv_d;
  logic       falling;
  logic       rising;

  assign quiet      = cmd_is_quiet(cmd);
  assign base_state = banks_idle ? PS_IDLE : PS_ACTIVE;
  assign falling    = cke_prev & ~cke;
  assign rising     = ~cke_prev & cke;

  always_comb begin
    nxt         = state;
    ill_d       = 1'b0;
    inv_d       = 1'b0;
    guard_start = 1'b0;
    unique case (state)
      PS_IDLE, PS_ACTIVE: begin
        if (guard_busy) begin
          nxt = PS_IDLE;
          if (!quiet) ill_d = 1'b1;
        end else begin
          if (cmd == CK_MODESET && !banks_idle) ill_d = 1'b1;
          if (falling) begin
            if (!banks_idle)              nxt = PS_SUSPEND;
            else if (cmd == CK_REFRESH)   nxt = PS_SREF;
            else if (cmd == CK_BSTOP)     nxt = PS_DPD;
            else                          nxt = PS_PDOWN;
          end else begin
            nxt = base_state;
          end
        end
      end
      PS_SUSPEND: begin
        if (cke) nxt = base_state;
      end
      PS_PDOWN, PS_SREF: begin
        if (cke_prev) begin
          inv_d = 1'b1;
        end else if (rising) begin
          if (quiet) nxt = PS_IDLE;
          else       ill_d = 1'b1;
        end
      end
      PS_DPD: begin
        if (cke_prev) begin
          inv_d = 1'b1;
        end else if (rising) begin
          nxt         = PS_IDLE;
          guard_start = 1'b1;
          if (!quiet) ill_d = 1'b1;
        end
      end
      default: nxt = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PS_IDLE;
      illegal_q <= 1'b0;
      invalid_q <= 1'b0;
    end else begin
      state     <= nxt;
      illegal_q <= ill_d;
      invalid_q <= inv_d;
    end
  end

endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker
  import sdram_pwr_pkg::*;
#(
  parameter int unsigned GUARD_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  output logic [2:0] pwr_state,
  output logic       illegal_cmd,
  output logic       invalid_cke,
  output logic       guard_busy
);

  cmd_kind_t  cmd_k;
  pwr_state_t st;
  logic       cke_prev;
  logic       g_start;

  sdram_cmd_decode dec_i (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .kind  (cmd_k)
  );

  cke_history #(.RESET_LEVEL(1'b1)) hist_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cke_prev (cke_prev)
  );

  exit_guard_timer #(.GUARD_CYCLES(GUARD_CYCLES)) guard_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (g_start),
    .cke   (cke),
    .busy  (guard_busy)
  );

  pwr_state_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke         (cke),
    .cke_prev    (cke_prev),
    .cmd         (cmd_k),
    .banks_idle  (banks_idle),
    .guard_busy  (guard_busy),
    .state       (st),
    .guard_start (g_start),
    .illegal_q   (illegal_cmd),
    .invalid_q   (invalid_cke)
  );

  assign pwr_state = st;

endmodule

// File: rtl/sdram_cke_tracker_chk.sv
module sdram_cke_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       banks_idle,
  input logic [2:0] pwr_state,
  input logic       illegal_cmd,
  input logic       invalid_cke,
  input logic       guard_busy
);

  logic       cke_d;
  logic [3:0] pins;
  logic       quiet;
  logic       low_pwr;

  assign pins    = {cs_n, ras_n, cas_n, we_n};
  assign quiet   = cs_n | (pins == 4'b0111);
  assign low_pwr = (pwr_state == 3'd3) | (pwr_state == 3'd4) | (pwr_state == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n) cke_d <= 1'b1;
    else        cke_d <= cke;
  end

  // R2
  state_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state <= 3'd5);

  // R2
  sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0 && !guard_busy && banks_idle && cke_d && !cke && pins == 4'b0001)
    |=> pwr_state == 3'd4);

  // R3
  dpd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0 && !guard_busy && banks_idle && cke_d && !cke && pins == 4'b0110)
    |=> pwr_state == 3'd5);

  // R5
  suspend_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd2 && cke) |=> pwr_state != 3'd2);

  // R7
  quiet_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 3'd3 || pwr_state == 3'd4) && !cke_d && cke && quiet)
    |=> (pwr_state == 3'd0 && !illegal_cmd));

  // R8
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && cke_d) |=> (invalid_cke && $stable(pwr_state)));

  // R9
  dpd_exit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd5 && !cke_d && cke) |=> (guard_busy && pwr_state == 3'd0));

  // R10
  window_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_busy && !quiet) |=> illegal_cmd);

  // R11
  window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_busy && !cke) |=> (guard_busy && pwr_state == 3'd0));

endmodule

bind sdram_cke_tracker sdram_cke_tracker_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .banks_idle  (banks_idle),
  .pwr_state   (pwr_state),
  .illegal_cmd (illegal_cmd),
  .invalid_cke (invalid_cke),
  .guard_busy  (guard_busy)
);

// File: tb/sdram_cke_tracker_tb_top.sv
module sdram_cke_tracker_tb_top;

  localparam int G = 40;
  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cke;
  logic [3:0] cmd;
  logic       banks_idle;
  logic [2:0] pwr_state;
  logic       illegal_cmd;
  logic       invalid_cke;
  logic       guard_busy;

  int total = 0;
  int bad   = 0;
  int ticks = 0;
  bit done  = 0;

  logic [2:0] m_st;
  logic       m_prev;
  int         m_cnt;
  logic       e_ill;
  logic       e_inv;

  always #2 clk = ~clk;

  sdram_cke_tracker #(.GUARD_CYCLES(G)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke         (cke),
    .cs_n        (cmd[3]),
    .ras_n       (cmd[2]),
    .cas_n       (cmd[1]),
    .we_n        (cmd[0]),
    .banks_idle  (banks_idle),
    .pwr_state   (pwr_state),
    .illegal_cmd (illegal_cmd),
    .invalid_cke (invalid_cke),
    .guard_busy  (guard_busy)
  );

  function automatic void model_reset();
    m_st = 3'd0; m_prev = 1'b1; m_cnt = 0; e_ill = 1'b0; e_inv = 1'b0;
  endfunction

  function automatic void model_step(logic c, logic [3:0] k, logic bi);
    logic       q;
    logic [2:0] n;
    logic       st_g;
    q = k[3] || (k == C_NOP);
    n = m_st; e_ill = 1'b0; e_inv = 1'b0; st_g = 1'b0;
    if (m_st == 3'd0 || m_st == 3'd1) begin
      if (m_cnt != 0) begin
        n = 3'd0;
        e_ill = !q;
      end else begin
        e_ill = (k == C_MRS) && !bi;
        if (m_prev && !c)
          n = !bi ? 3'd2 : (k == C_REF) ? 3'd4 : (k == C_BST) ? 3'd5 : 3'd3;
        else
          n = bi ? 3'd0 : 3'd1;
      end
    end else if (m_st == 3'd2) begin
      if (c) n = bi ? 3'd0 : 3'd1;
    end else begin
      if (m_prev) e_inv = 1'b1;
      else if (c) begin
        if (m_st == 3'd5) begin
          n = 3'd0; st_g = 1'b1; e_ill = !q;
        end else if (q) n = 3'd0;
        else e_ill = 1'b1;
      end
    end
    if (st_g) m_cnt = G;
    else if (m_cnt != 0) m_cnt = c ? m_cnt - 1 : G;
    m_prev = c;
    m_st = n;
  endfunction

  task automatic check(string tag);
    logic [5:0] act;
    logic [5:0] exp;
    act = {pwr_state, illegal_cmd, invalid_cke, guard_busy};
    exp = {m_st, e_ill, e_inv, (m_cnt != 0)};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {state,ill,inv,busy} actual=%b_%b_%b_%b expected=%b_%b_%b_%b",
               tag, act[5:3], act[2], act[1], act[0], exp[5:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic cyc(logic c, logic [3:0] k, logic bi, string tag);
    cke = c; cmd = k; banks_idle = bi;
    model_step(c, k, bi);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      ticks++;
      if (ticks > 100000 && !done) begin
        done = 1;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; cke = 1'b1; cmd = C_DES; banks_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    check("R1 reset");

    cyc(1, C_REF, 1, "R2 auto refresh stays idle");
    cyc(0, C_REF, 1, "R2 self refresh entry");
    cyc(0, C_NOP, 1, "R6 self refresh hold");
    cyc(0, C_ACT, 1, "R6 self refresh hold any cmd");
    cyc(1, C_ACT, 1, "R7 illegal exit command");
    cyc(1, C_NOP, 1, "R8 invalid previous cke");
    cyc(0, C_NOP, 1, "R8 invalid again");
    cyc(0, C_NOP, 1, "R13 flags cleared");
    cyc(1, C_DES, 1, "R7 deselect exit");
    cyc(0, C_DES, 1, "R4 power down entry");
    cyc(0, C_NOP, 1, "R6 power down hold");
    cyc(1, C_NOP, 1, "R7 power down exit");
    cyc(0, C_BST, 1, "R3 deep power down entry");
    cyc(0, C_NOP, 1, "R6 deep power down hold");
    cyc(1, C_RD,  1, "R10 exit edge read with guard R9");
    for (int i = 0; i < 10; i++) cyc(1, C_NOP, 1, "R9 window running");
    cyc(1, C_ACT, 1, "R10 active in window");
    cyc(0, C_BST, 1, "R11 cke low restarts window");
    for (int i = 0; i < G; i++) cyc(1, C_DES, 0, "R9 full window after restart");
    cyc(1, C_NOP, 1, "R13 window over");
    cyc(1, C_ACT, 0, "R5 active");
    cyc(1, C_MRS, 0, "R12 mode set with open bank");
    cyc(0, C_NOP, 0, "R5 suspend entry");
    cyc(0, C_RD,  0, "R5 suspend hold");
    cyc(1, C_NOP, 0, "R5 suspend exit to active");
    cyc(1, C_MRS, 1, "R12 mode set all idle");

    for (int i = 0; i < 6000; i++) begin
      logic       c;
      logic [3:0] k;
      int         r;
      c = cke;
      if ($urandom % 6 == 0) c = ~c;
      r = $urandom % 10;
      case (r)
        0, 1: k = C_NOP;
        2:    k = C_DES;
        3, 4: k = C_REF;
        5, 6: k = C_BST;
        7:    k = C_MRS;
        8:    k = C_ACT;
        default: k = C_RD;
      endcase
      cyc(c, k, ($urandom % 4) != 0, "R13 random vs model");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule